// File: doc/BRIEF.md
# Scan Sync and Line-Interrupt Timer

This block produces the timing skeleton for a small video system that has no frame buffer and relies on the CPU to fetch display data. A free-running horizontal counter, clocked by the CPU clock, shapes a horizontal sync pulse. A short 3-bit scan-line counter advances at the start of each pulse. Vertical sync is held in a flag that software opens with a dedicated strobe and closes with a port write. The two syncs are merged into one composite sync signal.

The same horizontal pulse can also drive the CPU's non-maskable interrupt and wait lines. This lets the CPU run useful work between lines and then return to the display routine in step with the beam. Two port writes switch that generation on and off. While it is on, WAIT is withheld from a halted CPU, and the vertical sync controls are locked out.

Top module: `sync_nmi_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, all of the following hold: NMI generation is off, `nmi_req` and `wait_req` are 0, `csync` is 0, `video_white` is 1 and `line_cnt` is 0.
- R2: The horizontal counter starts at 0 after reset and advances once per clock, wrapping after 207 counts. Horizontal sync is high while the count is from 16 to 31 inclusive. It therefore first appears in the cycle after the 16th clock edge following reset, lasts 16 cycles, and repeats every 207 cycles.
- R3: `csync` is the OR of horizontal and vertical sync. `video_white` is 1 exactly when `csync` is 0.
- R4: While NMI generation is on, `nmi_req` equals the horizontal sync level.
- R5: While NMI generation is on, `wait_req` equals horizontal sync AND NOT `cpu_halt`. A halted CPU never sees `wait_req` high.
- R6: While NMI generation is off, `nmi_req` and `wait_req` are both 0.
- R7: An I/O write (`io_wr`=1) with `io_addr`=6 turns NMI generation on from the next cycle. One with `io_addr`=5 turns it off. Writes with any other `io_addr` value leave it unchanged.
- R8: An I/O write with `io_addr`=7 while NMI generation is off clears `line_cnt` to 0 and ends vertical sync from the next cycle, and this takes priority over a line increment or sync start in the same cycle. While NMI generation is on, such a write has no effect.
- R9: A `vsync_start` pulse while NMI generation is off raises vertical sync from the next cycle until an R8 clear. While NMI generation is on, the pulse is ignored.
- R10: `line_cnt` increments by one (wrapping modulo 8) in the cycle after each rising edge of horizontal sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | Decoded I/O write strobe, one cycle |
| io_addr | input | 3 | Low three address bits of the I/O access |
| cpu_halt | input | 1 | CPU halted status, active high |
| vsync_start | input | 1 | Request to begin vertical sync, one cycle |
| csync | output | 1 | Composite sync, 1 = sync level |
| video_white | output | 1 | 1 = output at full white level (no sync) |
| nmi_req | output | 1 | Non-maskable interrupt request, active high |
| wait_req | output | 1 | CPU wait request, active high |
| line_cnt | output | 3 | Scan-line counter |

## Verification
All state changes take effect one clock edge after the stimulus that causes them. Port writes, `vsync_start` and the horizontal count are therefore visible in the cycle after the edge that samples them. The line count shows the increment one cycle after horizontal sync rises, that is, in the cycle in which the count is 17. `wait_req` is the one output that reacts to `cpu_halt` in the same cycle, through logic alone. The scoreboard's driver applies each input set at the falling edge and queues the outputs its model predicts after the following rising edge. The monitor compares them a quarter period after that rising edge, while the same inputs are still applied.

// File: rtl/sync_nmi_pkg.sv
package sync_nmi_pkg;

    parameter int H_TOTAL = 207;
    parameter int HS_BEG  = 16;
    parameter int HS_END  = 32;
    parameter int LINE_W  = 3;

    localparam logic [2:0] PORT_NMI_ON    = 3'd6;
    localparam logic [2:0] PORT_NMI_OFF   = 3'd5;
    localparam logic [2:0] PORT_FRAME_END = 3'd7;

    typedef enum logic [1:0] {
        IO_NONE,
        IO_NMI_ON,
        IO_NMI_OFF,
        IO_FRAME_END
    } io_cmd_e;

    typedef struct packed {
        logic hsync;
        logic hs_rise;
    } hpulse_t;

    function automatic io_cmd_e decode_io(input logic wr, input logic [2:0] addr);
        io_cmd_e c;
        c = IO_NONE;
        if (wr) begin
            case (addr)
                PORT_NMI_ON:    c = IO_NMI_ON;
                PORT_NMI_OFF:   c = IO_NMI_OFF;
                PORT_FRAME_END: c = IO_FRAME_END;
                default:        c = IO_NONE;
            endcase
        end
        return c;
    endfunction

    function automatic logic in_window(input int cnt, input int lo, input int hi);
        return (cnt >= lo) && (cnt < hi);
    endfunction

endpackage

// File: rtl/sync_hcount.sv
module sync_hcount
    import sync_nmi_pkg::*;
#(
    parameter int H_TOT = H_TOTAL,
    parameter int HB    = HS_BEG,
    parameter int HE    = HS_END,
    localparam int CW   = $clog2(H_TOT)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt_o,
    output hpulse_t       hp_o
);
    localparam logic [CW-1:0] LAST = CW'(H_TOT - 1);

    logic [CW-1:0] cnt_q;
    logic          hs_d;
    logic          hs_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            hs_d  <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            hs_d  <= hs_now;
        end
    end

    always_comb begin
        hs_now        = in_window(int'(cnt_q), HB, HE);
        hp_o.hsync    = hs_now;
        hp_o.hs_rise  = hs_now & ~hs_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sync_nmi_ctrl.sv
module sync_nmi_ctrl
    import sync_nmi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  io_cmd_e cmd,
    input  logic    hsync,
    input  logic    cpu_halt,
    output logic    nmi_en_o,
    output logic    nmi_req_o,
    output logic    wait_req_o
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            case (cmd)
                IO_NMI_ON:  en_q <= 1'b1;
                IO_NMI_OFF: en_q <= 1'b0;
                default:    en_q <= en_q;
            endcase
        end
    end

    always_comb begin
        nmi_req_o  = en_q & hsync;
        wait_req_o = en_q & hsync & ~cpu_halt;
    end

    assign nmi_en_o = en_q;
endmodule

// File: rtl/sync_vline.sv
module sync_vline
    import sync_nmi_pkg::*;
#(
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  io_cmd_e       cmd,
    input  logic          nmi_en,
    input  logic          hs_rise,
    input  logic          vsync_start,
    output logic          vsync_o,
    output logic [LW-1:0] line_o
);
    logic          vs_q;
    logic [LW-1:0] line_q;
    logic          frame_clr;

    assign frame_clr = (cmd == IO_FRAME_END) && !nmi_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q   <= 1'b0;
            line_q <= '0;
        end else if (frame_clr) begin
            vs_q   <= 1'b0;
            line_q <= '0;
        end else begin
            if (vsync_start && !nmi_en) vs_q <= 1'b1;
            if (hs_rise) line_q <= line_q + 1'b1;
        end
    end

    assign vsync_o = vs_q;
    assign line_o  = line_q;
endmodule

// File: rtl/sync_nmi_gen.sv
module sync_nmi_gen
    import sync_nmi_pkg::*;
#(
    parameter int H_TOT = H_TOTAL,
    parameter int HB    = HS_BEG,
    parameter int HE    = HS_END,
    parameter int LW    = LINE_W,
    localparam int CW   = $clog2(H_TOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          io_wr,
    input  logic [2:0]    io_addr,
    input  logic          cpu_halt,
    input  logic          vsync_start,
    output logic          csync,
    output logic          video_white,
    output logic          nmi_req,
    output logic          wait_req,
    output logic [LW-1:0] line_cnt
);
    io_cmd_e       cmd;
    hpulse_t       hp;
    logic [CW-1:0] h_cnt;
    logic          hsync;
    logic          vsync;
    logic          nmi_en;

    assign cmd   = decode_io(io_wr, io_addr);
    assign hsync = hp.hsync;

    sync_hcount #(.H_TOT(H_TOT), .HB(HB), .HE(HE)) u_hcnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (h_cnt),
        .hp_o  (hp)
    );

    sync_nmi_ctrl u_nmi (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .hsync      (hsync),
        .cpu_halt   (cpu_halt),
        .nmi_en_o   (nmi_en),
        .nmi_req_o  (nmi_req),
        .wait_req_o (wait_req)
    );

    sync_vline #(.LW(LW)) u_vline (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .nmi_en      (nmi_en),
        .hs_rise     (hp.hs_rise),
        .vsync_start (vsync_start),
        .vsync_o     (vsync),
        .line_o      (line_cnt)
    );

    always_comb begin
        csync       = hsync | vsync;
        video_white = ~csync;
    end
endmodule

// File: rtl/sync_nmi_chk.sv
module sync_nmi_chk #(
    parameter int CW    = 8,
    parameter int LW    = 3,
    parameter int H_TOT = 207,
    parameter int HB    = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          io_wr,
    input logic [2:0]    io_addr,
    input logic          cpu_halt,
    input logic          nmi_en,
    input logic          hsync,
    input logic          vsync,
    input logic [CW-1:0] h_cnt,
    input logic [LW-1:0] line_cnt,
    input logic          nmi_req,
    input logic          wait_req
);
    logic clr_now;
    assign clr_now = io_wr && (io_addr == 3'd7) && !nmi_en;

    // R2
    h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_cnt == CW'(H_TOT - 1)) |=> (h_cnt == '0));

    // R2
    hs_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> (h_cnt == CW'(HB)));

    // R4
    nmi_follow_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_en |-> (nmi_req == hsync));

    // R5
    halt_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_halt |-> !wait_req);

    // R6
    nmi_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !nmi_en |-> (!nmi_req && !wait_req));

    // R8
    frame_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_now |=> (line_cnt == '0 && !vsync));

    // R9
    vs_locked_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_en |=> $stable(vsync));

    // R10
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(hsync) && !clr_now) |=> (line_cnt == $past(line_cnt) + 1'b1));
endmodule

bind sync_nmi_gen sync_nmi_chk #(.CW(CW), .LW(LW), .H_TOT(H_TOT), .HB(HB)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .cpu_halt (cpu_halt),
    .nmi_en   (nmi_en),
    .hsync    (hsync),
    .vsync    (vsync),
    .h_cnt    (h_cnt),
    .line_cnt (line_cnt),
    .nmi_req  (nmi_req),
    .wait_req (wait_req)
);

// File: tb/tb_sync_nmi_gen.sv
`timescale 1ns/1ps
module tb_sync_nmi_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic [2:0] io_addr = 3'd0;
    logic       cpu_halt = 1'b0;
    logic       vsync_start = 1'b0;
    logic       csync, video_white, nmi_req, wait_req;
    logic [2:0] line_cnt;

    always #10 clk = ~clk;

    sync_nmi_gen dut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
        .cpu_halt(cpu_halt), .vsync_start(vsync_start),
        .csync(csync), .video_white(video_white), .nmi_req(nmi_req),
        .wait_req(wait_req), .line_cnt(line_cnt)
    );

    typedef struct {
        logic       cs;
        logic       wh;
        logic       nmi;
        logic       wt;
        logic [2:0] line;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // reference state, from the requirements
    int   m_h = 0;
    bit   m_hs_prev = 0;
    int   m_line = 0;
    bit   m_vs = 0;
    bit   m_en = 0;

    task automatic cyc(input bit r, input bit wr, input logic [2:0] a,
                       input bit halt, input bit vs, input string tag);
        exp_t e;
        bit hs_old, rise, en_old, hs;
        @(negedge clk);
        rst = r; io_wr = wr; io_addr = a; cpu_halt = halt; vsync_start = vs;
        if (r) begin
            m_h = 0; m_hs_prev = 0; m_line = 0; m_vs = 0; m_en = 0;
        end else begin
            hs_old = (m_h >= 16) && (m_h < 32);
            rise = hs_old && !m_hs_prev;
            m_hs_prev = hs_old;
            en_old = m_en;
            m_h = (m_h + 1) % 207;
            if (wr && a == 3'd6) m_en = 1;
            else if (wr && a == 3'd5) m_en = 0;
            if (wr && a == 3'd7 && !en_old) begin
                m_line = 0; m_vs = 0;
            end else begin
                if (rise) m_line = (m_line + 1) % 8;
                if (vs && !en_old) m_vs = 1;
            end
        end
        hs = (m_h >= 16) && (m_h < 32);
        e.cs   = hs | m_vs;
        e.wh   = !(hs | m_vs);
        e.nmi  = m_en & hs;
        e.wt   = m_en & hs & !halt;
        e.line = 3'(m_line);
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic run(input int n, input bit halt, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, halt, 1'b0, tag);
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_cmp++;
                if (csync !== e.cs || video_white !== e.wh || nmi_req !== e.nmi ||
                    wait_req !== e.wt || line_cnt !== e.line) begin
                    n_bad++;
                    $display("FAIL %s: got cs=%b wh=%b nmi=%b wait=%b line=%0d exp cs=%b wh=%b nmi=%b wait=%b line=%0d",
                             e.tag, csync, video_white, nmi_req, wait_req, line_cnt,
                             e.cs, e.wh, e.nmi, e.wt, e.line);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no finish, expected end of run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "R1 reset");
        cyc(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R1 first cycle");
        // R2 R3 R6: free run with NMI off, hsync period and composite sync
        run(430, 1'b0, "R2 R3 R6 idle");
        // R7: unrelated port leaves NMI off
        cyc(1'b0, 1'b1, 3'd3, 1'b0, 1'b0, "R7 other port");
        run(220, 1'b0, "R7 R6 still off");
        // R7: enable
        cyc(1'b0, 1'b1, 3'd6, 1'b0, 1'b0, "R7 enable");
        run(220, 1'b0, "R4 R5 running");
        run(220, 1'b1, "R5 halted");
        // mixed halt inside one pulse
        run(14, 1'b0, "R5 mix");
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 3'd0, bit'(i % 3 == 0), 1'b0, "R5 halt toggle");
        // R9: vsync request ignored while enabled
        cyc(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, "R9 ignored start");
        run(5, 1'b0, "R9 no vsync");
        // R8: frame end ignored while enabled
        cyc(1'b0, 1'b1, 3'd7, 1'b0, 1'b0, "R8 ignored clear");
        run(5, 1'b0, "R8 line kept");
        // R7: disable
        cyc(1'b0, 1'b1, 3'd5, 1'b0, 1'b0, "R7 disable");
        run(30, 1'b0, "R6 off again");
        // R9: vsync start while disabled
        cyc(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, "R9 start");
        run(250, 1'b0, "R3 R9 vsync held");
        // R8: clear while disabled
        cyc(1'b0, 1'b1, 3'd7, 1'b0, 1'b0, "R8 clear");
        run(40, 1'b0, "R8 R3 after clear");
        // R10: line count wraps over several lines
        run(207 * 9, 1'b0, "R10 line wrap");
        // R8: clear coinciding with start; clear wins
        cyc(1'b0, 1'b1, 3'd7, 1'b0, 1'b1, "R8 clear beats start");
        run(10, 1'b0, "R8 R9 after combined");
        @(posedge clk);
        #8;
        @(posedge clk);
        #8;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule